// File: doc/BRIEF.md
# Quasi-Bidirectional Pin Bank Controller

This block drives the pad-control signals for a bank of open-drain-style pins that act as input and output at once. Each pin has an output latch. A latch at 0 turns on a strong pull-down. A latch at 1 turns the pull-down off, so an external weak pull-up sets the high level. When a latch goes from 0 to 1, a strong pull-up is enabled for one clock to speed the rising edge. The pin is never driven high for longer than that one clock.

The core writes the latches through a masked write port. It reads back the actual pin levels. These levels are sampled at all times, pass through a synchronizer and then land in a read-data register. A pin whose latch is 1 therefore works as an input: an external device can pull it low, and the read returns 0.

Top module: `qbio_port_ctrl`

## Requirements
- R1: During and after reset every latch is 1, `pd_en` is all zero, `pu_strong` is all zero and `rd_data` is all ones.
- R2: A pin whose latch holds 0 has `pd_en` at 1 in every cycle that the latch stays 0.
- R3: A pin whose latch holds 1 has `pd_en` at 0.
- R4: A write that moves a latch from 0 to 1 makes `pu_strong` of that pin 1 for exactly the one cycle after the write edge, and 0 again in the cycle after that.
- R5: A write that leaves a latch at 1, or that moves it from 1 to 0, or leaves it at 0, produces no `pu_strong` pulse.
- R6: On a write, a pin whose `wr_mask` bit is 0 keeps its latch. A pin whose mask bit is 1 takes its `wr_data` bit.
- R7: `pd_en` and `pu_strong` are never both 1 on the same pin in the same cycle.
- R8: `rd_data` bit i, read after clock edge n, equals the level of `pad_in` bit i sampled at edge n-2. This path has two synchronizer flops and one read register, and it does not depend on the latch value.
- R9: A pin whose latch is 1 and that an external device pulls low reads back 0 through `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the latch bank |
| wr_mask | input | WIDTH | Per-pin write enable, 1 = update |
| wr_data | input | WIDTH | New latch values for masked pins |
| pad_in | input | WIDTH | Sampled pad levels |
| rd_data | output | WIDTH | Synchronized pad levels |
| pd_en | output | WIDTH | Strong pull-down enable per pin |
| pu_strong | output | WIDTH | One-cycle strong pull-up enable per pin |

## Verification
The pad is modelled as a weak-high wire that the controller's pull-down or an external device can pull low. A behavioural model is compared with the design on every cycle.

The stimulus covers several cases:
- A full-bank clear followed by a full-bank set separates the rising-edge pulse from the held level.
- Rewriting ones and clearing ones shows that only 0-to-1 transitions pulse.
- Sparse masks show that unmasked pins are untouched.
- External pull-downs on pins latched high separate the read path from the latch.
- A long pseudo-random run of writes, masks and external pulls checks all rules together.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
   localparam int unsigned QB_MIN_SYNC = 2;

   function automatic logic merge_bit(input logic old_v, input logic new_v, input logic sel);
      return sel ? new_v : old_v;
   endfunction
endpackage

// File: rtl/qbio_latch_bank.sv
module qbio_latch_bank #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_mask,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] rise_q
);
   import qbio_pkg::*;

   initial begin
      assert (WIDTH >= 1) else $error("WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic nxt;
      always_comb nxt = wr_en ? merge_bit(latch_q[i], wr_data[i], wr_mask[i]) : latch_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            latch_q[i] <= 1'b1;
            rise_q[i]  <= 1'b0;
         end else begin
            latch_q[i] <= nxt;
            rise_q[i]  <= nxt & ~latch_q[i];
         end
      end

      AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !wr_mask[i]) |=> $stable(latch_q[i])); // R6
   end
endmodule

// File: rtl/qbio_in_sync.sv
module qbio_in_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   import qbio_pkg::*;
   localparam int unsigned LAST = STAGES - 1;

   initial begin
      assert (STAGES >= QB_MIN_SYNC) else $error("STAGES below minimum");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '1;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[LAST];
endmodule

// File: rtl/qbio_port_ctrl.sv
module qbio_port_ctrl #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_mask,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] rd_data,
   output logic [WIDTH-1:0] pd_en,
   output logic [WIDTH-1:0] pu_strong
);
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] rise_q;
   logic [WIDTH-1:0] sync_q;

   qbio_latch_bank #(.WIDTH(WIDTH)) i_latch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask),
      .wr_data(wr_data), .latch_q(latch_q), .rise_q(rise_q)
   );

   qbio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '1;
      else        rd_data <= sync_q;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_drv
      assign pd_en[i]     = ~latch_q[i];
      assign pu_strong[i] = rise_q[i] & latch_q[i];

      AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
         !(pd_en[i] && pu_strong[i])); // R7
      AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
         pu_strong[i] |=> !pu_strong[i]); // R4
      AST_PULSE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pu_strong[i]) |-> $past(pd_en[i])); // R5
   end
endmodule

// File: tb/test_qbio_port_ctrl.sv
module test_qbio_port_ctrl;
   localparam int W = 8;

   logic clk = 0, rst_n = 0;
   logic wr_en = 0;
   logic [W-1:0] wr_mask = '0, wr_data = '0, ext_low = '0;
   logic [W-1:0] rd_data, pd_en, pu_strong, pad_in;
   int tests = 0, fails = 0;

   always #4 clk = ~clk;

   // resolved pad: weak high unless pulled low by controller or external device
   assign pad_in = ~(pd_en | ext_low);

   qbio_port_ctrl #(.WIDTH(W), .SYNC_STAGES(2)) i_qbio_port_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
      .pad_in(pad_in), .rd_data(rd_data), .pd_en(pd_en), .pu_strong(pu_strong)
   );

   // reference model
   logic [W-1:0] m_latch = '1, m_pu = '0, m_rd = '1;
   logic [W-1:0] padq[$];

   always @(posedge clk) begin
      logic [W-1:0] nl;
      if (!rst_n) begin
         m_latch = '1; m_pu = '0; m_rd = '1;
         padq.delete(); padq.push_back('1); padq.push_back('1);
      end else begin
         padq.push_back(~((~m_latch) | ext_low));
         m_rd = padq.pop_front();
         nl = wr_en ? ((m_latch & ~wr_mask) | (wr_data & wr_mask)) : m_latch;
         m_pu = nl & ~m_latch;
         m_latch = nl;
      end
   end

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison away from the active edge
   always @(negedge clk) if (rst_n) begin
      chk("R2/R3 pd_en", pd_en, ~m_latch);
      chk("R4/R5 pu_strong", pu_strong, m_pu);
      chk("R8 rd_data", rd_data, m_rd);
      chk("R7 no fight", pd_en & pu_strong, '0);
   end

   task automatic wr(input logic [W-1:0] m, input logic [W-1:0] d);
      @(negedge clk); wr_en = 1; wr_mask = m; wr_data = d;
      @(negedge clk); wr_en = 0; wr_mask = '0; wr_data = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      idle(3);
      chk("R1 reset pd", pd_en, '0);
      chk("R1 reset pu", pu_strong, '0);
      chk("R1 reset rd", rd_data, '1);
      @(negedge clk); rst_n = 1;
      idle(3);
      chk("R1 post-reset rd", rd_data, '1);
      // R2: clear all
      wr('1, '0);
      chk("R2 pd on", pd_en, '1);
      chk("R5 no pulse 1->0", pu_strong, '0);
      idle(4);
      chk("R2 pd held", pd_en, '1);
      chk("R8 reads low", rd_data, '0);
      // R4: set pins 0,3,7 ; pulse visible in cycle after write edge
      @(negedge clk); wr_en = 1; wr_mask = 8'h89; wr_data = 8'hFF;
      @(negedge clk); wr_en = 0; wr_mask = '0;
      chk("R4 pulse on", pu_strong, 8'h89);
      chk("R6 others held", pd_en, 8'h76);
      @(negedge clk);
      chk("R4 pulse off", pu_strong, '0);
      chk("R3 pd off", pd_en & 8'h89, '0);
      // R5: rewrite ones, no pulse
      @(negedge clk); wr_en = 1; wr_mask = 8'h89; wr_data = 8'h89;
      @(negedge clk); wr_en = 0; wr_mask = '0;
      chk("R5 no pulse 1->1", pu_strong, '0);
      // R6: unmasked data ignored
      wr(8'h00, 8'hFF);
      chk("R6 mask zero holds", pd_en, 8'h76);
      // R9: external pull on latch-1 pin
      wr('1, '1);
      @(negedge clk); ext_low = 8'h24;
      idle(3);
      chk("R9 external low read", rd_data, 8'hDB);
      @(negedge clk); ext_low = '0;
      idle(3);
      chk("R9 released", rd_data, '1);
      // mixed random run
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         wr_en = lfsr[0] | lfsr[5];
         wr_mask = lfsr[15:8] ^ lfsr[7:0];
         wr_data = lfsr[11:4];
         ext_low = (lfsr[3:0] == 4'h7) ? lfsr[14:7] : ext_low & {W{lfsr[2]}};
      end
      @(negedge clk); wr_en = 0; ext_low = '0;
      idle(5);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule